// File: doc/BRIEF.md
# Ramp Controller Configuration Register Slave

This block is the bus-facing register file of a clock frequency-ramp controller. Software reaches it through a single-cycle, word-addressed read/write port. Writes take effect at the clock edge on which `bus_wr_en` is high. Reads are combinational from `bus_addr`. The port is a plain register port with no valid/ready handshake, because it carries no data stream and every access completes in its own cycle.

Software uses the block in a fixed order:
- It sets root-enable in the command word and polls until the update-busy flag drops.
- It fills the configuration words.
- For each configuration entry in turn, it writes the entry number together with the update-enable trigger into the update word, then polls until the matching acknowledge bit appears.
- It writes the update word back to zero and polls until the acknowledge field is empty.

The busy-clear delay and the commit and clear delays are modelled by parameterised countdowns. The pulse-swallowing datapath that consumes the committed words is outside this block.

Top module: `ramp_cfg_regs`

## Requirements
- R1: Synchronous active-low reset gives these values. The command word (word 0) reads 0x0000_0001: busy is 1 and root-enable is 0. Every configuration word reads 0. The update word (word 24) reads 0.
- R2: Command word bit 1 (root-enable) is read/write. Bit 0 (busy) is read-only, and writing it has no effect. All other bits of the command word read 0.
- R3: While root-enable is 1 and busy is 1, a countdown runs. Busy reads 0 exactly BUSY_LAT clock edges after the edge that wrote root-enable to 1, and reads 1 before that. If root-enable is cleared before the count ends, busy stays 1 and the count starts over. Once cleared, busy stays 0 until reset.
- R4: Words 4 to 14, 16 and 20 (byte offsets 0x10 to 0x38, 0x40 and 0x50) are full 32-bit read/write configuration words.
- R5: Any other word address reads 0, and writes to it change nothing. This includes words 1 to 3, 15, 17 to 19, 21 to 23, 25 and 26.
- R6: The update word stores the entry number in bits [3:0] and the update-enable trigger in bit 8. Bits [7:4] and [15:9] read 0. The acknowledge field [31:16] is read-only, and bus writes to it are ignored.
- R7: While update-enable is 1 and the acknowledge field is 0, a countdown runs. Exactly ACK_LAT edges after the edge that set update-enable, the acknowledge field becomes the one-hot value with bit 16+entry set. The field never holds more than one bit.
- R8: The acknowledge field and the stored update bits do not clear by themselves. They hold as long as the entry number or update-enable is nonzero.
- R9: Once the update word is written to zero while an acknowledge is present, the field keeps its value and then reads 0 exactly ACK_LAT edges after that write.
- R10: If update-enable is cleared before the commit countdown ends, no acknowledge is produced. A later trigger starts a fresh full-length countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 5 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
The handshakes are driven in four patterns, and each one separates a different kind of fault:
- An uninterrupted root-enable countdown, and a commit, are sampled one edge before and exactly on the expected edge, which catches off-by-one latency.
- A root-enable that is withdrawn early, and a commit that is aborted, show whether the counters restart or wrongly keep their progress.
- Commits of entries 0, 15 and 2 exercise both ends of the acknowledge field and show whether the one-hot position follows the entry number.
- Writes to unmapped words and to the read-only bits are each followed by reads of the nearby mapped words, so a bad address decode or a writable status bit shows up at the port.

// File: rtl/ramp_cfg_pkg.sv
package ramp_cfg_pkg;
  localparam int REG_W      = 32;
  localparam int ADDR_W     = 5;
  localparam int NUM_SLOTS  = 2 ** ADDR_W;
  localparam int ENTRY_W    = 4;
  localparam int ACK_W      = 2 ** ENTRY_W;
  localparam int CMD_IDX    = 0;
  localparam int UPD_IDX    = 24;
  localparam int UPD_EN_BIT = 8;

  function automatic logic is_cfg_word(input int idx);
    return ((idx >= 4) && (idx <= 14)) || (idx == 16) || (idx == 20);
  endfunction
endpackage

// File: rtl/rcr_delay_timer.sv
module rcr_delay_timer #(
  parameter int LAT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (LAT < 2) ? 1 : $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == CW'(LAT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || done) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  initial begin
    assert_lat_positive_R3 : assert (LAT >= 1);
  end

  // R3 / R7: the countdown never runs past its limit
  assert_cnt_range_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(LAT));
endmodule

// File: rtl/rcr_cmd_reg.sv
module rcr_cmd_reg #(
  parameter int BUSY_LAT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wr_root,
  output logic busy,
  output logic root_en
);
  logic busy_q;
  logic root_q;
  logic ready_done;

  rcr_delay_timer #(.LAT(BUSY_LAT)) u_ready_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (root_q && busy_q),
    .done  (ready_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      root_q <= 1'b0;
    end else begin
      if (wr_hit) root_q <= wr_root;
      if (ready_done) busy_q <= 1'b0;
    end
  end

  assign busy    = busy_q;
  assign root_en = root_q;

  // R3: busy only falls, and only while root-enable was set
  assert_busy_no_rise_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(busy_q));
  assert_busy_fall_root_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(root_q));
endmodule

// File: rtl/rcr_word_bank.sv
module rcr_word_bank
  import ramp_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata
);
  logic [REG_W-1:0] slot_w [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    if (is_cfg_word(i)) begin : g_store
      logic [REG_W-1:0] word_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          word_q <= '0;
        end else if (wr_en && (addr == ADDR_W'(i))) begin
          word_q <= wdata;
        end
      end
      assign slot_w[i] = word_q;
    end else begin : g_hole
      assign slot_w[i] = '0;
    end
  end

  assign rdata = slot_w[addr];
endmodule

// File: rtl/rcr_update_ctrl.sv
module rcr_update_ctrl
  import ramp_cfg_pkg::*;
#(
  parameter int ACK_LAT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic               wr_trig,
  output logic [REG_W-1:0]   rdata
);
  logic [ENTRY_W-1:0] entry_q;
  logic               trig_q;
  logic [ACK_W-1:0]   ack_q;
  logic               run_commit;
  logic               run_clear;
  logic               commit_done;
  logic               clear_done;

  assign run_commit = trig_q && (ack_q == '0);
  assign run_clear  = (ack_q != '0) && !trig_q && (entry_q == '0);

  rcr_delay_timer #(.LAT(ACK_LAT)) u_commit_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_commit),
    .done  (commit_done)
  );

  rcr_delay_timer #(.LAT(ACK_LAT)) u_clear_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_clear),
    .done  (clear_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_q <= '0;
      trig_q  <= 1'b0;
      ack_q   <= '0;
    end else begin
      if (wr_hit) begin
        entry_q <= wr_entry;
        trig_q  <= wr_trig;
      end
      if (commit_done) begin
        ack_q <= ACK_W'(1) << entry_q;
      end else if (clear_done) begin
        ack_q <= '0;
      end
    end
  end

  always_comb begin
    rdata                  = '0;
    rdata[ENTRY_W-1:0]     = entry_q;
    rdata[UPD_EN_BIT]      = trig_q;
    rdata[REG_W-1:REG_W-ACK_W] = ack_q;
  end

  // R7: at most one acknowledge bit
  assert_ack_onehot_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_q));
  // R7: an acknowledge appears only after the trigger was held
  assert_ack_needs_trig_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_q != '0) && ($past(ack_q) == '0)) |-> $past(trig_q));
  // R8: no self-clearing while the update word is nonzero
  assert_ack_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_q != '0) && (trig_q || (entry_q != '0))) |=> (ack_q == $past(ack_q)));
endmodule

// File: rtl/ramp_cfg_regs.sv
module ramp_cfg_regs
  import ramp_cfg_pkg::*;
#(
  parameter int BUSY_LAT = 8,
  parameter int ACK_LAT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata
);
  logic             cmd_hit;
  logic             upd_hit;
  logic             busy;
  logic             root_en;
  logic [REG_W-1:0] bank_rdata;
  logic [REG_W-1:0] upd_rdata;

  assign cmd_hit = bus_wr_en && (bus_addr == ADDR_W'(CMD_IDX));
  assign upd_hit = bus_wr_en && (bus_addr == ADDR_W'(UPD_IDX));

  rcr_cmd_reg #(.BUSY_LAT(BUSY_LAT)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (cmd_hit),
    .wr_root (bus_wdata[1]),
    .busy    (busy),
    .root_en (root_en)
  );

  rcr_word_bank u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (bus_wr_en),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (bank_rdata)
  );

  rcr_update_ctrl #(.ACK_LAT(ACK_LAT)) u_upd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit   (upd_hit),
    .wr_entry (bus_wdata[ENTRY_W-1:0]),
    .wr_trig  (bus_wdata[UPD_EN_BIT]),
    .rdata    (upd_rdata)
  );

  always_comb begin
    if (bus_addr == ADDR_W'(CMD_IDX)) begin
      bus_rdata = {{(REG_W-2){1'b0}}, root_en, busy};
    end else if (bus_addr == ADDR_W'(UPD_IDX)) begin
      bus_rdata = upd_rdata;
    end else begin
      bus_rdata = bank_rdata;
    end
  end

  // R5: a hole in the map always reads zero
  assert_hole_reads_zero_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (!is_cfg_word(int'(bus_addr)) && (bus_addr != ADDR_W'(CMD_IDX)) &&
     (bus_addr != ADDR_W'(UPD_IDX))) |-> (bus_rdata == '0));
endmodule

// File: tb/ramp_cfg_regs_tb_top.sv
module ramp_cfg_regs_tb_top;
  localparam int LAT_B = 8;
  localparam int LAT_A = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  ramp_cfg_regs #(.BUSY_LAT(LAT_B), .ACK_LAT(LAT_A)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (wr_en),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [4:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_check("R1 cmd", 5'd0, 32'h1);
    rd_check("R1 cfg4", 5'd4, 32'h0);
    rd_check("R1 cfg20", 5'd20, 32'h0);
    rd_check("R1 upd", 5'd24, 32'h0);
  endtask

  task automatic t_root_ready;
    wr(5'd0, 32'hFFFF_FFFE);
    rd_check("R2 busy ro, root set", 5'd0, 32'h3);
    idle(3);
    wr(5'd0, 32'h0);
    idle(LAT_B + 4);
    rd_check("R3 withdrawn keeps busy", 5'd0, 32'h1);
    wr(5'd0, 32'h2);
    idle(LAT_B - 1);
    rd_check("R3 busy one edge early", 5'd0, 32'h3);
    idle(1);
    rd_check("R3 busy cleared on time", 5'd0, 32'h2);
    wr(5'd0, 32'h1);
    rd_check("R2 root cleared, busy stays 0", 5'd0, 32'h0);
    wr(5'd0, 32'h2);
    idle(LAT_B + 2);
    rd_check("R3 busy never returns", 5'd0, 32'h2);
  endtask

  task automatic t_cfg_words;
    logic [4:0] idx [6] = '{5'd4, 5'd11, 5'd12, 5'd14, 5'd16, 5'd20};
    for (int i = 0; i < 6; i++) wr(idx[i], 32'hA5A5_0000 ^ (32'h1111 * (i + 1)));
    for (int i = 0; i < 6; i++)
      rd_check("R4 cfg word readback", idx[i], 32'hA5A5_0000 ^ (32'h1111 * (i + 1)));
  endtask

  task automatic t_holes;
    logic [4:0] hole [6] = '{5'd2, 5'd15, 5'd17, 5'd21, 5'd25, 5'd26};
    for (int i = 0; i < 6; i++) wr(hole[i], 32'hDEAD_BEEF);
    for (int i = 0; i < 6; i++) rd_check("R5 hole reads zero", hole[i], 32'h0);
    rd_check("R5 neighbour 14 intact", 5'd14, 32'hA5A5_0000 ^ 32'h4444);
    rd_check("R5 neighbour 16 intact", 5'd16, 32'hA5A5_0000 ^ 32'h5555);
    rd_check("R5 cmd intact", 5'd0, 32'h2);
    rd_check("R5 upd intact", 5'd24, 32'h0);
  endtask

  task automatic commit(input string tag, input logic [3:0] e);
    wr(5'd24, 32'h0000_0100 | e);
    idle(LAT_A - 1);
    rd_check({tag, " R7 no ack early"}, 5'd24, 32'h100 | e);
    idle(1);
    rd_check({tag, " R7 ack on time"}, 5'd24, (32'h1 << (16 + e)) | 32'h100 | e);
    idle(LAT_A + 3);
    rd_check({tag, " R8 ack holds"}, 5'd24, (32'h1 << (16 + e)) | 32'h100 | e);
    wr(5'd24, 32'h0);
    idle(LAT_A - 1);
    rd_check({tag, " R9 ack held before clear"}, 5'd24, 32'h1 << (16 + e));
    idle(1);
    rd_check({tag, " R9 ack cleared on time"}, 5'd24, 32'h0);
  endtask

  task automatic t_update_fields;
    wr(5'd24, 32'hFFFF_FEF3);
    rd_check("R6 field masking, ack ro", 5'd24, 32'h0000_0003);
    idle(LAT_A + 2);
    rd_check("R6 no trigger no ack", 5'd24, 32'h0000_0003);
    wr(5'd24, 32'h0);
  endtask

  task automatic t_abort;
    wr(5'd24, 32'h0000_0103);
    idle(LAT_A - 3);
    wr(5'd24, 32'h0);
    idle(LAT_A + 3);
    rd_check("R10 abort gives no ack", 5'd24, 32'h0);
    commit("R10 fresh", 4'd2);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    t_reset();
    t_root_ready();
    t_cfg_words();
    t_holes();
    t_update_fields();
    commit("e0", 4'd0);
    commit("e15", 4'd15);
    t_abort();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule